// File: doc/BRIEF.md
# Processor Supervisor with Triangular-Ramp Watchdog

This block is a clocked model of a processor supervisor. It drives one active-low reset line from two sources. The first is a supply-good flag, which must be high for a programmable power-on delay before reset is released. The second is a watchdog, which the processor has to service with rising edges on a kick input. The supply-good flag is assumed to be already filtered and synchronous to the clock.

The watchdog behaves like a timing capacitor. A single up/down counter, the ramp, stands in for the capacitor voltage. The bottom threshold is ramp value 0 and the top threshold is `SPAN`. The ramp climbs by 10 per clock while charging and falls by 1 per clock while discharging, so the reset hold time is one tenth of the timeout.

A kick is honoured only while the ramp falls, and only outside a guard band of `SPAN/20` at each end of the ramp. An accepted kick sends the ramp back up to the top threshold. If the ramp reaches the bottom threshold with no accepted kick, reset is pulled low and the ramp charges back to the top while reset stays low. Pulling the enable input low parks the watchdog with the ramp at the bottom threshold, while supply monitoring keeps running.

The controller is a state machine with six states:

| State | Meaning |
|---|---|
| `ST_UNDERV` | Supply not good. |
| `ST_PORDLY` | Power-on delay is counting. |
| `ST_WDOFF` | Watchdog parked by the enable input. |
| `ST_CHARGE` | Ramp climbing after start, restart or an accepted kick. |
| `ST_DISCH` | Ramp falling; kicks are accepted here. |
| `ST_HOLD` | Ramp climbing after a timeout, with reset low. |

Its transitions are listed below. The first one has priority over all the others, and the transitions to `ST_WDOFF` have priority over the ramp transitions.

- Supply-bad: any state goes to `ST_UNDERV`.
- Supply-up: `ST_UNDERV` goes to `ST_PORDLY`.
- Delay-done: `ST_PORDLY` goes to `ST_CHARGE` if enabled, otherwise to `ST_WDOFF`.
- Enable-on: `ST_WDOFF` goes to `ST_CHARGE`.
- Disable: `ST_CHARGE`, `ST_DISCH` or `ST_HOLD` goes to `ST_WDOFF`.
- Reach-top: `ST_CHARGE` or `ST_HOLD` goes to `ST_DISCH`.
- Kick: `ST_DISCH` goes to `ST_CHARGE`.
- Reach-bottom: `ST_DISCH` goes to `ST_HOLD`. This wins over Kick in the same cycle.

Top module: `psup_ramp_wdt`

## Requirements
- R1: While the block's reset input is low, and on every clock edge where the supply-good flag is low, the reset output is low after that edge, whatever the enable input is.
- R2: After the supply-good flag rises and stays high, the reset output stays low for `DELAY_CYC` further clock edges and goes high on edge `DELAY_CYC+1`, counted from the first edge that sees the flag high.
- R3: When the power-on delay expires with the watchdog enabled, the ramp starts from the bottom threshold in the charging phase. With no kick, the reset output goes low on edge `SPAN/10 + 1 + SPAN + 1` after it went high.
- R4: Once the ramp starts to fall from the top threshold with no accepted kick, the reset output goes low on edge `SPAN+1` after the edge on which the fall began.
- R5: A rising edge on the kick input that the phase logic sees while the ramp falls inside the guard limits sends the ramp back to charging. The reset output then stays high past the moment it would otherwise have gone low.
- R6: After a timeout, the reset output stays low for exactly `SPAN/10 + 1` clock edges, because the ramp climbs by 10 per edge up to `SPAN`. It then goes high as the ramp starts to fall again, and the ramp never exceeds `SPAN`.
- R7: The kick input reaches the phase logic through two synchronizing flops and an edge detector, so a rise is seen two edges after it is sampled. A rise seen while the ramp is above `SPAN - SPAN/20`, or below `SPAN/20`, is ignored. This includes the cycle in which the ramp sits at the bottom threshold.
- R8: Kick edges that arrive while the ramp is climbing, whether after a kick, after a start or during the reset hold, have no effect on when reset next goes low.
- R9: With supply good, a low enable input keeps the reset output high indefinitely. Raising enable restarts the ramp from the bottom threshold in the charging phase, so the next timeout follows the R3 timing counted from the edge that sees enable high.
- R10: A drop of supply-good aborts both the watchdog and any power-on delay in progress. A full new delay of `DELAY_CYC+1` edges is needed after supply-good returns.
- R11: Only rising kick edges count. A kick input held high restarts the ramp once, and the following fall times out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset of the block's own state |
| vgood_i | input | 1 | Filtered supply-good flag, high when the supply is above its threshold |
| wd_en_i | input | 1 | Watchdog enable; low parks the ramp at the bottom threshold |
| kick_i | input | 1 | Service input from the processor, asynchronous; rising edges count |
| rst_no | output | 1 | Active-low supervisor reset, registered |

## Verification
Two of the block's functions can land in the same cycle: accepting a kick, and detecting the timeout when the ramp reaches the bottom threshold. The bench provokes this by timing a kick pulse so that its synchronized edge reaches the phase logic in the last cycle of the fall, with the ramp at 0. It then checks that reset still goes low exactly `SPAN+1` edges after the fall began.

The bench also places kick edges exactly one cycle on either side of each guard limit. At each of these points it judges the outcome only from the cycle in which the reset output falls or fails to fall.

// File: rtl/psup_pkg.sv
package psup_pkg;

    // Controller states of the supervisor
    typedef enum logic [2:0] {
        ST_UNDERV = 3'd0,
        ST_PORDLY = 3'd1,
        ST_WDOFF  = 3'd2,
        ST_CHARGE = 3'd3,
        ST_DISCH  = 3'd4,
        ST_HOLD   = 3'd5
    } psup_state_e;

    // Ramp climbs this many units per clock and falls by one,
    // which makes the reset hold time a tenth of the timeout
    localparam int RAMP_UP_STEP = 10;

    // Guard band at each end of the fall, as a divisor of the span (5 %)
    localparam int GUARD_DIV = 20;

endpackage

// File: rtl/psup_kick_edge.sv
module psup_kick_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [SYNC_STAGES-1:0] sync_d;
    logic                   prev_q;

    // Shift chain built stage by stage
    assign sync_d[0] = kick_i;
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_chain
        assign sync_d[g] = sync_q[g-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // One-cycle pulse on a synchronized rising edge
    assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/psup_por_timer.sv
module psup_por_timer #(
    parameter int DELAY_CYC = 40
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);

    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Cleared whenever the delay is not running, so an abort always
    // forces a full new delay
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/psup_ramp.sv
module psup_ramp
    import psup_pkg::*;
#(
    parameter int SPAN = 200,
    localparam int RW  = $clog2(SPAN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          up_i,
    output logic [RW-1:0] ramp_o,
    output logic          top_o,
    output logic          bot_o,
    output logic          window_o
);

    localparam logic [RW-1:0] TOP    = RW'(SPAN);
    localparam logic [RW-1:0] WIN_LO = RW'(SPAN / GUARD_DIV);
    localparam logic [RW-1:0] WIN_HI = RW'(SPAN - SPAN / GUARD_DIV);

    logic [RW-1:0] ramp_q;
    logic [RW-1:0] ramp_d;
    logic [RW:0]   climb;

    assign climb = {1'b0, ramp_q} + (RW+1)'(RAMP_UP_STEP);

    // Parked at the bottom threshold when idle, saturating at both ends
    always_comb begin
        if (!run_i) begin
            ramp_d = '0;
        end else if (up_i) begin
            ramp_d = (climb >= {1'b0, TOP}) ? TOP : climb[RW-1:0];
        end else begin
            ramp_d = (ramp_q == '0) ? '0 : ramp_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ramp_q <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    assign ramp_o   = ramp_q;
    assign top_o    = (ramp_q == TOP);
    assign bot_o    = (ramp_q == '0);
    assign window_o = (ramp_q >= WIN_LO) && (ramp_q <= WIN_HI);

endmodule

// File: rtl/psup_ramp_wdt.sv
module psup_ramp_wdt
    import psup_pkg::*;
#(
    parameter int DELAY_CYC   = 40,
    parameter int SPAN        = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vgood_i,
    input  logic wd_en_i,
    input  logic kick_i,
    output logic rst_no
);

    localparam int RW = $clog2(SPAN + 1);

    psup_state_e   state_q;
    psup_state_e   state_d;
    logic          rst_q;
    logic          kick_rise;
    logic          por_run;
    logic          por_done;
    logic          ramp_run;
    logic          ramp_up;
    logic [RW-1:0] ramp_q;
    logic          ramp_top;
    logic          ramp_bot;
    logic          ramp_win;

    // Kick synchronizer and edge detector
    psup_kick_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_kick (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .kick_i(kick_i),
        .rise_o(kick_rise)
    );

    // Power-on delay counter
    assign por_run = (state_q == ST_PORDLY);

    psup_por_timer #(
        .DELAY_CYC(DELAY_CYC)
    ) i_por (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (por_run),
        .done_o(por_done)
    );

    // Ramp datapath: runs in the three watchdog states, climbs in two
    assign ramp_run = (state_q == ST_CHARGE) || (state_q == ST_DISCH) ||
                      (state_q == ST_HOLD);
    assign ramp_up  = (state_q == ST_CHARGE) || (state_q == ST_HOLD);

    psup_ramp #(
        .SPAN(SPAN)
    ) i_ramp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (ramp_run),
        .up_i    (ramp_up),
        .ramp_o  (ramp_q),
        .top_o   (ramp_top),
        .bot_o   (ramp_bot),
        .window_o(ramp_win)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_UNDERV;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: supply loss first, then enable, then ramp events
    always_comb begin
        state_d = state_q;
        if (!vgood_i) begin
            state_d = ST_UNDERV;
        end else begin
            unique case (state_q)
                ST_UNDERV: state_d = ST_PORDLY;
                ST_PORDLY: begin
                    if (por_done) begin
                        state_d = wd_en_i ? ST_CHARGE : ST_WDOFF;
                    end
                end
                ST_WDOFF: begin
                    if (wd_en_i) begin
                        state_d = ST_CHARGE;
                    end
                end
                ST_CHARGE: begin
                    if (!wd_en_i) begin
                        state_d = ST_WDOFF;
                    end else if (ramp_top) begin
                        state_d = ST_DISCH;
                    end
                end
                ST_DISCH: begin
                    if (!wd_en_i) begin
                        state_d = ST_WDOFF;
                    end else if (ramp_bot) begin
                        state_d = ST_HOLD;
                    end else if (kick_rise && ramp_win) begin
                        state_d = ST_CHARGE;
                    end
                end
                ST_HOLD: begin
                    if (!wd_en_i) begin
                        state_d = ST_WDOFF;
                    end else if (ramp_top) begin
                        state_d = ST_DISCH;
                    end
                end
                default: state_d = ST_UNDERV;
            endcase
        end
    end

    // Output register: reset released only in running or parked states
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rst_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_CHARGE, ST_DISCH, ST_WDOFF: rst_q <= 1'b1;
                default:                       rst_q <= 1'b0;
            endcase
        end
    end

    assign rst_no = rst_q;

endmodule

// File: rtl/psup_ramp_wdt_chk.sv
module psup_ramp_wdt_chk
    import psup_pkg::*;
#(
    parameter int SPAN = 200,
    localparam int RW  = $clog2(SPAN + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          vgood_i,
    input logic          wd_en_i,
    input logic          rst_no,
    input psup_state_e   st_i,
    input logic [RW-1:0] ramp_i,
    input logic          rise_i
);

    localparam logic [RW-1:0] TOP    = RW'(SPAN);
    localparam logic [RW-1:0] WIN_HI = RW'(SPAN - SPAN / GUARD_DIV);

    p_uv_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vgood_i |=> !rst_no);

    p_por_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vgood_i) |=> !rst_no);

    p_fall_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_DISCH && ramp_i != '0 && vgood_i && wd_en_i && !rise_i)
        |=> (ramp_i == $past(ramp_i) - 1'b1));

    p_timeout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_DISCH && ramp_i == '0 && vgood_i && wd_en_i) |=> !rst_no);

    p_ramp_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ramp_i <= TOP);

    p_top_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_DISCH && ramp_i > WIN_HI && vgood_i && wd_en_i)
        |=> (st_i == ST_DISCH));

    p_climb_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_CHARGE && ramp_i != TOP && vgood_i && wd_en_i)
        |=> (st_i == ST_CHARGE));

    p_halt_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vgood_i && !wd_en_i && rst_no) |=> rst_no);

endmodule

bind psup_ramp_wdt psup_ramp_wdt_chk #(
    .SPAN(SPAN)
) i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vgood_i(vgood_i),
    .wd_en_i(wd_en_i),
    .rst_no (rst_no),
    .st_i   (state_q),
    .ramp_i (ramp_q),
    .rise_i (kick_rise)
);

// File: tb/test_psup_ramp_wdt.sv
`timescale 1ns/1ps
module test_psup_ramp_wdt;

    localparam int DELAY = 40;
    localparam int SPAN  = 200;
    localparam int CHG   = SPAN / 10 + 1;   // climb bottom to top, edges
    localparam int TOUT  = SPAN + 1;        // fall to timeout, edges
    localparam int GRD   = SPAN / 20;
    localparam int LAT   = 2;               // kick synchronizer latency

    logic clk = 1'b0;
    logic rst_n, vgood, wd_en, kick;
    logic rst_out;

    int n_checks = 0;
    int n_errors = 0;
    int since_d  = 0;   // edges since the current fall began

    always #2.5 clk = ~clk;

    psup_ramp_wdt #(
        .DELAY_CYC(DELAY),
        .SPAN(SPAN),
        .SYNC_STAGES(LAT)
    ) i_psup_ramp_wdt (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .vgood_i(vgood),
        .wd_en_i(wd_en),
        .kick_i (kick),
        .rst_no (rst_out)
    );

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            since_d++;
        end
        @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (since_d < t) adv(1);
    endtask

    task automatic chk(input string req, input logic exp);
        n_checks++;
        if (rst_out !== exp) begin
            n_errors++;
            $display("FAIL %s at edge %0d: rst_no actual %b expected %b",
                     req, since_d, rst_out, exp);
        end
    endtask

    // Timeout at 201 after fall start, then hold, leaving since_d = 0
    task automatic expect_timeout(input string req);
        wait_until(TOUT - 1);      chk(req, 1'b1);
        wait_until(TOUT);          chk(req, 1'b0);
        wait_until(TOUT + CHG - 1); chk("R6 hold low", 1'b0);
        wait_until(TOUT + CHG);    chk("R6 hold end", 1'b1);
        since_d = 0;
    endtask

    task automatic pulse_kick(input int at);
        wait_until(at);
        kick = 1'b1;
        adv(1);
        kick = 1'b0;
    endtask

    // Park and restart: fall begins 21 edges after enable is seen high
    task automatic realign();
        wd_en = 1'b0;
        adv(2);
        wd_en = 1'b1;
        since_d = -CHG - 1;
        adv(1);
        wait_until(0);
    endtask

    task automatic t_powerup();
        vgood = 1'b1;
        adv(DELAY);     chk("R2 still in delay", 1'b0);
        adv(1);         chk("R2 delay expired", 1'b1);
        since_d = -CHG;
        expect_timeout("R3 first timeout");
    endtask

    task automatic t_timeout();
        expect_timeout("R4 no kick");
    endtask

    task automatic t_kick_mid();
        pulse_kick(100);
        wait_until(TOUT);          chk("R5 kick accepted", 1'b1);
        wait_until(TOUT + 1);      chk("R5 kick accepted", 1'b1);
        // seen at ramp 98, climb from 97 to top, new fall 201 later
        wait_until(315);           chk("R5 new fall timing", 1'b1);
        wait_until(316);           chk("R5 new fall timing", 1'b0);
        wait_until(316 + CHG);     chk("R6 hold end", 1'b1);
        since_d = 0;
    endtask

    task automatic t_guard();
        pulse_kick(GRD - LAT - 1);           // ramp 191 when seen
        expect_timeout("R7 top guard ignored");
        pulse_kick(GRD - LAT);               // ramp 190 when seen
        wait_until(TOUT + 1);      chk("R7 top limit accepted", 1'b1);
        realign();
        pulse_kick(SPAN - GRD - LAT + 1);    // ramp 9 when seen
        expect_timeout("R7 bottom guard ignored");
        pulse_kick(SPAN - GRD - LAT);        // ramp 10 when seen
        wait_until(TOUT + 1);      chk("R7 bottom limit accepted", 1'b1);
        realign();
        pulse_kick(SPAN - LAT);              // seen at ramp 0, same cycle as timeout
        expect_timeout("R7 kick at bottom loses");
    endtask

    task automatic t_climb_kicks();
        realign();
        pulse_kick(TOUT + 4);                // lands in hold
        wait_until(TOUT);          chk("R8 timeout before hold kick", 1'b0);
        wait_until(TOUT + CHG - 1); chk("R8 hold kick ignored", 1'b0);
        wait_until(TOUT + CHG);    chk("R8 hold kick ignored", 1'b1);
        since_d = 0;
        expect_timeout("R8 after hold kick");
        wd_en = 1'b0; adv(2); wd_en = 1'b1;
        since_d = -CHG - 1; adv(1);
        pulse_kick(-CHG + 3);                // lands while charging
        expect_timeout("R8 charge kick ignored");
    endtask

    task automatic t_level_kick();
        wait_until(100);
        kick = 1'b1;
        wait_until(315);           chk("R11 first edge accepted", 1'b1);
        wait_until(316);           chk("R11 first edge accepted", 1'b0);
        wait_until(316 + CHG);     chk("R6 hold end", 1'b1);
        since_d = 0;
        expect_timeout("R11 held level ignored");
        kick = 1'b0;
    endtask

    task automatic t_enable();
        wait_until(50);
        wd_en = 1'b0;
        adv(1);                    chk("R9 parked high", 1'b1);
        wait_until(450);           chk("R9 no timeout while parked", 1'b1);
        vgood = 1'b0;
        adv(1);                    chk("R1 undervoltage while parked", 1'b0);
        vgood = 1'b1;
        adv(DELAY);                chk("R2 delay with watchdog off", 1'b0);
        adv(1);                    chk("R2 delay with watchdog off", 1'b1);
        adv(30);                   chk("R9 still parked", 1'b1);
        wd_en = 1'b1;
        since_d = -CHG - 1;
        adv(1);
        expect_timeout("R9 restart from bottom");
    endtask

    task automatic t_undervoltage();
        wait_until(100);
        vgood = 1'b0;
        adv(1);                    chk("R1 supply drop", 1'b0);
        adv(4);
        vgood = 1'b1;
        adv(20);                   chk("R10 partial delay", 1'b0);
        vgood = 1'b0;
        adv(1);
        vgood = 1'b1;
        adv(DELAY);                chk("R10 full new delay", 1'b0);
        adv(1);                    chk("R10 full new delay", 1'b1);
        since_d = -CHG;
        expect_timeout("R10 fresh watchdog");
    endtask

    initial begin
        rst_n = 1'b0;
        vgood = 1'b0;
        wd_en = 1'b1;
        kick  = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 block reset", 1'b0);
        rst_n = 1'b1;
        adv(3);
        chk("R1 supply low", 1'b0);
        t_powerup();
        t_timeout();
        t_kick_mid();
        t_guard();
        t_climb_kicks();
        t_level_kick();
        t_enable();
        t_undervoltage();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule